// File: doc/BRIEF.md
# Unaligned Big-Endian Word Load Unit

This block fetches one 32-bit big-endian word from a byte-addressed data memory. The start address may be any byte address. The memory holds 32-bit words. Within each word the bytes sit in little-endian lanes, so a byte fetch must flip the two low address bits to find its lane.

A client hands over a request address with a valid/ready handshake. The unit then drives a synchronous single-port memory with a one-cycle read latency, and returns the word on a response interface as a one-cycle valid pulse.

An aligned request takes the fast path, a single full-word read. Any other start address takes the slow path: four byte reads at consecutive addresses in four consecutive cycles. Each byte is shifted to its slot and OR-merged into the result.

The controller has four states:

- `S_IDLE` waits for a request, with ready high.
- `S_WORD_RD` issues the full-word read.
- `S_BYTE_RD` issues the four byte reads, counting them with a 2-bit index.
- `S_RESP` presents the result for one cycle.

Its transitions are:

- IDLE to WORD_RD when the request is accepted and its address is aligned.
- IDLE to BYTE_RD when the request is accepted and its address is unaligned.
- WORD_RD to RESP unconditionally.
- BYTE_RD to itself while the index is below 3.
- BYTE_RD to RESP when the index is 3.
- RESP to IDLE unconditionally.

Top module: `be_word_loader`

## Requirements
- R1: After reset, `req_ready` is 1, and `resp_valid` and `mem_rd_en` are 0.
- R2: A request whose address has bits [1:0] equal to 0 causes exactly one memory read, at word address `addr[11:2]`. The response data is that memory word unchanged.
- R3: A request whose address has bits [1:0] not equal to 0 causes exactly four memory reads, in consecutive cycles, for the byte addresses start+0, start+1, start+2 and start+3, in that order. Each read uses word address `byte[11:2]`.
- R4: The byte at byte address b is taken from memory word `b[11:2]`, in lane L = `b[1:0]` XOR 3, that is bits [8L+7:8L]. The XOR is applied to the sum of the start address and the offset.
- R5: On the slow path, the byte at offset k (k = 0..3) is placed at bits [31-8k:24-8k] of the response. For the fast path this is equivalent to the word read.
- R6: Byte addresses wrap modulo 4096, so start+k past byte 4095 continues at byte 0.
- R7: `req_ready` is 0 from the cycle after acceptance through the response cycle. Requests presented while `req_ready` is 0 have no effect. `resp_valid` is high for exactly one cycle per request.
- R8: Counting the acceptance edge as edge 0, `resp_valid` is high after clock edge 1 on the fast path and after clock edge 4 on the slow path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_addr | input | 12 | Start byte address |
| req_ready | output | 1 | Unit idle and able to accept |
| resp_valid | output | 1 | One-cycle response strobe |
| resp_data | output | 32 | Big-endian word result |
| mem_rd_en | output | 1 | Memory read enable |
| mem_addr | output | 10 | Memory word address |
| mem_rd_data | input | 32 | Read data, one cycle after `mem_rd_en` |

## Verification
Some properties are checked by assertions on every cycle:

- Ready falls after every accepted request.
- The response strobe never lasts two cycles and never coincides with ready or with a memory read.
- During the slow path, each byte read targets the address one above the previous byte read.

Other properties only the bench scenarios can show, by comparing against a reference model of the memory:

- Lane selection and the shift-merge ordering.
- Wrap-around at the top of the 4 KB space.
- The exact read counts and read addresses for each path.
- The response latency.
- That requests presented while busy are ignored.

// File: rtl/ldu_pkg.sv
package ldu_pkg;

    localparam int WORD_BITS  = 32;
    localparam int LANE_BITS  = 8;
    localparam int LANE_COUNT = WORD_BITS / LANE_BITS;
    localparam int LANE_IDX_W = $clog2(LANE_COUNT);

    typedef enum logic [1:0] {
        S_IDLE    = 2'd0,
        S_WORD_RD = 2'd1,
        S_BYTE_RD = 2'd2,
        S_RESP    = 2'd3
    } ldu_state_e;

endpackage

// File: rtl/ldu_addr_gen.sv
module ldu_addr_gen #(
    parameter int ADDR_W   = 12,
    parameter int IDX_W    = 2,
    parameter int LANE_XOR = 3
) (
    input  logic [ADDR_W-1:0]       base,
    input  logic [IDX_W-1:0]        offset,
    output logic [ADDR_W-1:0]       byte_addr,
    output logic [ADDR_W-IDX_W-1:0] word_addr,
    output logic [IDX_W-1:0]        lane
);
    localparam logic [IDX_W-1:0] XOR_K = IDX_W'(LANE_XOR);

    // Offset added to the unmodified base; truncation gives the wrap.
    always_comb begin
        byte_addr = base + ADDR_W'(offset);
        word_addr = byte_addr[ADDR_W-1:IDX_W];
        lane      = byte_addr[IDX_W-1:0] ^ XOR_K;
    end
endmodule

// File: rtl/ldu_lane_pick.sv
module ldu_lane_pick
    import ldu_pkg::*;
(
    input  logic [WORD_BITS-1:0]  word_in,
    input  logic [LANE_IDX_W-1:0] lane,
    output logic [LANE_BITS-1:0]  byte_out
);
    logic [LANE_BITS-1:0] lanes [LANE_COUNT];

    for (genvar g = 0; g < LANE_COUNT; g++) begin : g_lane
        assign lanes[g] = word_in[g*LANE_BITS +: LANE_BITS];
    end

    assign byte_out = lanes[lane];
endmodule

// File: rtl/ldu_merge.sv
module ldu_merge
    import ldu_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  clear,
    input  logic                  wr_en,
    input  logic [LANE_IDX_W-1:0] slot,
    input  logic [LANE_BITS-1:0]  byte_in,
    output logic [WORD_BITS-1:0]  merged_final
);
    logic [WORD_BITS-1:0] acc_q;
    logic [WORD_BITS-1:0] placed;
    logic [WORD_BITS-1:0] placed_last;

    // Slot s occupies the s-th byte counting from the most significant end.
    always_comb begin
        placed      = '0;
        placed_last = '0;
        for (int s = 0; s < LANE_COUNT; s++) begin
            if (slot == LANE_IDX_W'(s))
                placed[WORD_BITS-1-s*LANE_BITS -: LANE_BITS] = byte_in;
        end
        placed_last[LANE_BITS-1:0] = byte_in;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            acc_q <= '0;
        else if (clear)
            acc_q <= '0;
        else if (wr_en)
            acc_q <= acc_q | placed;
    end

    // The last byte arrives in the response cycle and is merged combinationally.
    assign merged_final = acc_q | placed_last;
endmodule

// File: rtl/be_word_loader.sv
module be_word_loader
    import ldu_pkg::*;
#(
    parameter int ADDR_W   = 12,
    parameter int LANE_XOR = 3
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             req_valid,
    input  logic [ADDR_W-1:0]                req_addr,
    output logic                             req_ready,
    output logic                             resp_valid,
    output logic [WORD_BITS-1:0]             resp_data,
    output logic                             mem_rd_en,
    output logic [ADDR_W-LANE_IDX_W-1:0]     mem_addr,
    input  logic [WORD_BITS-1:0]             mem_rd_data
);
    localparam int WORD_AW = ADDR_W - LANE_IDX_W;
    localparam logic [LANE_IDX_W-1:0] LAST_IDX = LANE_IDX_W'(LANE_COUNT - 1);

    ldu_state_e              state_q, state_d;
    logic [ADDR_W-1:0]       base_q;
    logic [LANE_IDX_W-1:0]   idx_q;
    logic                    word_mode_q;
    logic [LANE_IDX_W-1:0]   prev_lane_q;
    logic                    accept;
    logic                    aligned;
    logic [LANE_IDX_W-1:0]   gen_offset;
    logic [ADDR_W-1:0]       byte_addr;
    logic [WORD_AW-1:0]      word_addr;
    logic [LANE_IDX_W-1:0]   lane;
    logic [LANE_BITS-1:0]    byte_now;
    logic [WORD_BITS-1:0]    merged_final;
    logic                    merge_wr;
    logic [LANE_IDX_W-1:0]   merge_slot;

    assign accept  = req_valid && req_ready;
    assign aligned = (req_addr[LANE_IDX_W-1:0] == '0);

    ldu_addr_gen #(
        .ADDR_W  (ADDR_W),
        .IDX_W   (LANE_IDX_W),
        .LANE_XOR(LANE_XOR)
    ) u_addr (
        .base     (base_q),
        .offset   (gen_offset),
        .byte_addr(byte_addr),
        .word_addr(word_addr),
        .lane     (lane)
    );

    ldu_lane_pick u_pick (
        .word_in (mem_rd_data),
        .lane    (prev_lane_q),
        .byte_out(byte_now)
    );

    ldu_merge u_merge (
        .clk         (clk),
        .rst_n       (rst_n),
        .clear       (accept),
        .wr_en       (merge_wr),
        .slot        (merge_slot),
        .byte_in     (byte_now),
        .merged_final(merged_final)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q     <= S_IDLE;
            base_q      <= '0;
            idx_q       <= '0;
            word_mode_q <= 1'b0;
            prev_lane_q <= '0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                base_q      <= req_addr;
                word_mode_q <= aligned;
                idx_q       <= '0;
            end else if (state_q == S_BYTE_RD) begin
                idx_q <= idx_q + 1'b1;
            end
            if (state_q == S_BYTE_RD)
                prev_lane_q <= lane;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:    if (accept) state_d = aligned ? S_WORD_RD : S_BYTE_RD;
            S_WORD_RD: state_d = S_RESP;
            S_BYTE_RD: if (idx_q == LAST_IDX) state_d = S_RESP;
            S_RESP:    state_d = S_IDLE;
            default:   state_d = S_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        req_ready  = 1'b0;
        resp_valid = 1'b0;
        mem_rd_en  = 1'b0;
        gen_offset = '0;
        merge_wr   = 1'b0;
        merge_slot = idx_q - 1'b1;
        resp_data  = merged_final;
        unique case (state_q)
            S_IDLE:    req_ready = 1'b1;
            S_WORD_RD: mem_rd_en = 1'b1;
            S_BYTE_RD: begin
                mem_rd_en  = 1'b1;
                gen_offset = idx_q;
                merge_wr   = (idx_q != '0);
            end
            S_RESP: begin
                resp_valid = 1'b1;
                resp_data  = word_mode_q ? mem_rd_data : merged_final;
            end
            default: ;
        endcase
    end
    assign mem_addr = word_addr;

    // R7
    busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);
    // R7
    resp_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |=> !resp_valid);
    // R7
    resp_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |-> (!req_ready && !mem_rd_en));
    // R3
    byte_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_BYTE_RD && idx_q != '0) |->
            (mem_rd_en && $past(mem_rd_en) &&
             ADDR_W'(byte_addr - $past(byte_addr)) == ADDR_W'(1)));
endmodule

// File: tb/tb_be_word_loader.sv
module tb_be_word_loader;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W = 12;
    localparam int WORDS = 1 << (ADDR_W - 2);

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [11:0] req_addr = '0;
    logic        req_ready, resp_valid, mem_rd_en;
    logic [31:0] resp_data;
    logic [9:0]  mem_addr;
    logic [31:0] mem_rd_data = '0;

    logic [31:0] mem [WORDS];
    logic [9:0]  rd_log [8];
    int          rd_cnt = 0;
    int          checks = 0;
    int          fails = 0;
    bit          done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    be_word_loader dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_ready(req_ready), .resp_valid(resp_valid), .resp_data(resp_data),
        .mem_rd_en(mem_rd_en), .mem_addr(mem_addr), .mem_rd_data(mem_rd_data)
    );

    always @(posedge clk) begin
        if (mem_rd_en) begin
            mem_rd_data <= mem[mem_addr];
            rd_log[rd_cnt % 8] <= mem_addr;
            rd_cnt <= rd_cnt + 1;
        end
    end

    function automatic logic [7:0] ref_byte(input int b);
        int a = b & 4095;
        int ln = (a & 3) ^ 3;
        return 8'((mem[a >> 2] >> (ln * 8)) & 32'hFF);
    endfunction

    function automatic logic [31:0] ref_word(input int a);
        logic [31:0] w = '0;
        for (int k = 0; k < 4; k++)
            w = w | (32'(ref_byte(a + k)) << (24 - 8 * k));
        return w;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    endtask

    // noise=1 keeps req_valid high with other addresses while busy (R7)
    task automatic do_load(input int a, input bit noise);
        int c0, lat, n;
        logic [31:0] got;
        bit unal = (a & 3) != 0;
        @(negedge clk);
        check(req_ready === 1'b1, "R7", "ready before request", req_ready, 1);
        req_valid = 1'b1;
        req_addr  = 12'(a);
        c0 = rd_cnt;
        @(posedge clk);
        @(negedge clk);
        lat = 1;
        if (noise) req_addr = 12'($urandom);
        else req_valid = 1'b0;
        while (!resp_valid && lat < 20) begin
            check(req_ready === 1'b0, "R7", "ready while busy", req_ready, 0);
            @(posedge clk);
            @(negedge clk);
            lat++;
            if (noise) req_addr = 12'($urandom);
        end
        req_valid = 1'b0;
        got = resp_data;
        check(resp_valid === 1'b1 && req_ready === 1'b0, "R7", "response strobe", resp_valid, 1);
        check(lat == (unal ? 5 : 2), "R8", "latency", lat, unal ? 5 : 2);
        check(got === ref_word(a), unal ? "R5" : "R2", "data", got, ref_word(a));
        n = rd_cnt - c0;
        check(n == (unal ? 4 : 1), unal ? "R3" : "R2", "read count", n, unal ? 4 : 1);
        for (int k = 0; k < (n < 4 ? n : 4); k++) begin
            int e = unal ? (((a + k) & 4095) >> 2) : (a >> 2);
            check(rd_log[(c0 + k) % 8] == 10'(e), "R6", "read address", rd_log[(c0 + k) % 8], e);
        end
        @(posedge clk);
        @(negedge clk);
        check(resp_valid === 1'b0 && req_ready === 1'b1, "R7", "single strobe", resp_valid, 0);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        checks++;
        fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        void'($urandom(32'd1234));
        for (int i = 0; i < WORDS; i++) mem[i] = $urandom;
        mem[0] = 32'h11223344;
        mem[1] = 32'h55667788;
        mem[WORDS-1] = 32'hA1B2C3D4;
        repeat (2) @(negedge clk);
        // R1 reset state
        check(req_ready === 1'b1, "R1", "ready in reset", req_ready, 1);
        check(resp_valid === 1'b0, "R1", "resp_valid in reset", resp_valid, 0);
        check(mem_rd_en === 1'b0, "R1", "mem_rd_en in reset", mem_rd_en, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(req_ready === 1'b1 && resp_valid === 1'b0, "R1", "idle after reset", req_ready, 1);
        // Directed: R2 aligned, R4 lane order, R5 placement
        do_load(0, 1'b0);
        check(ref_word(0) == 32'h11223344, "R4", "model lane order", ref_word(0), 32'h11223344);
        do_load(1, 1'b0);
        check(ref_word(1) == 32'h22334455, "R5", "model placement", ref_word(1), 32'h22334455);
        do_load(2, 1'b0);
        do_load(3, 1'b1);
        do_load(4, 1'b0);
        // R6 wrap
        do_load(4092, 1'b0);
        do_load(4093, 1'b0);
        check(ref_word(4093) == 32'hB2C3D411, "R6", "model wrap", ref_word(4093), 32'hB2C3D411);
        do_load(4094, 1'b1);
        do_load(4095, 1'b0);
        // Random mix
        for (int i = 0; i < 400; i++)
            do_load(int'($urandom % 4096), 1'($urandom));
        finish_run();
    end
endmodule